// File: doc/BRIEF.md
# Shared I2C Engine Arbiter

This block decides which of three agents drives a single shared I2C bit engine: a software register path, an autonomous hardware requester (for example a periodic link poller) and a microcontroller. Each agent asks for the engine and later gives it back. The arbiter holds a registered one-hot grant and a two-bit status word for software. It launches engine jobs with a start pulse and a job descriptor. The bit engine itself is outside the block. It is represented by the `eng_start`/`eng_abort` pulses going out and the `eng_done` pulse coming back.

Hardware has the highest priority and can take the engine from software in the middle of a job. The software job it interrupts is kept, with its descriptor, and is launched again once hardware has finished and software holds the grant again. A software GO issued while hardware owns the engine is either held for later or dropped, depending on a static option input. A lockout input reserves the engine for the microcontroller and blocks any new software grant. All ports are plain control and status signals. No data stream crosses the block's edge, so it has no valid/ready interface.

Top module: `i2c_engine_arb`

## Requirements
- R1: While reset is held and on the first cycle after it, every grant is low, `sw_status` reads idle (0), and `eng_start` and `eng_abort` are low.
- R2: When no agent holds the engine, the grant goes on the clock edge after the request is seen. When several agents request together, the order is hardware, then microcontroller, then software. At most one grant is high at a time.
- R3: Software claims the engine by holding `sw_use_req` high. It gives the engine back by pulsing `sw_done_use` while `sw_use_req` is low, and `sw_status` is idle one cycle later. Without that release, and without a hardware request, the software grant stays high.
- R4: `sw_status` reads 0 when idle, 1 when software owns the engine, 2 when hardware owns it and 3 when the microcontroller owns it.
- R5: While `mcu_only` is high, `gnt_sw` is never newly raised, even with `sw_use_req` held high. Once `mcu_only` drops, software is granted on the next edge.
- R6: A hardware request while software owns the engine moves the grant to hardware on the next edge. `eng_abort` pulses on that same edge if a software job was running.
- R7: An interrupted software job is launched again, with its original descriptor, on the edge after software is granted again. That regrant happens one edge after hardware's `eng_done` returns the arbiter to idle.
- R8: A `sw_go` pulse while hardware owns the engine is held and launched when software is granted again if `no_queue_go` is 0. If `no_queue_go` is 1, the pulse is dropped and no software start follows.
- R9: `sw_status_reset` is accepted only while `sw_status` is 1. It then pulses `eng_abort` if a job is running and clears the running and held software jobs. In any other status it is ignored: no abort is raised and any held GO is kept.
- R10: A `sw_go` while software owns an idle engine gives `eng_start` on the next edge with `eng_desc` equal to `sw_desc`. Hardware's job starts one edge after its grant, with `eng_desc` equal to `hw_desc`. `eng_start` is only high while software or hardware is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_use_req | input | 1 | Software level request for the engine |
| sw_done_use | input | 1 | Software release pulse |
| sw_go | input | 1 | Software job launch pulse |
| sw_desc | input | DESC_W | Software job descriptor |
| sw_status_reset | input | 1 | Software engine reset pulse |
| no_queue_go | input | 1 | 1: drop a software GO issued while hardware owns |
| mcu_only | input | 1 | Lockout reserving the engine for the microcontroller |
| mcu_req | input | 1 | Microcontroller level request |
| hw_req | input | 1 | Hardware requester level request |
| hw_desc | input | DESC_W | Hardware job descriptor |
| eng_done | input | 1 | Engine finished the current job |
| gnt_sw | output | 1 | Software grant |
| gnt_hw | output | 1 | Hardware grant |
| gnt_mcu | output | 1 | Microcontroller grant |
| sw_status | output | 2 | Owner code read by software |
| eng_start | output | 1 | Launch pulse to the engine |
| eng_desc | output | DESC_W | Descriptor of the launched job |
| eng_abort | output | 1 | Abort pulse for a running software job |

## Verification
The bench builds the arbiter with `DESC_W` = 12 instead of the default 8. Every descriptor pattern it uses sets bits above bit 7. A restart that replayed a truncated or stale descriptor therefore shows up as a mismatch on `eng_desc`. With that width, the preemption, queued-GO and reset scenarios can each tell the restarted job apart from the hardware job and from a fresh GO by descriptor value alone.

// File: rtl/i2c_engine_arb_pkg.sv
package i2c_engine_arb_pkg;
  // Owner code doubles as the software-visible status value.
  typedef enum logic [1:0] {
    OWN_IDLE = 2'd0,
    OWN_SW   = 2'd1,
    OWN_HW   = 2'd2,
    OWN_MCU  = 2'd3
  } owner_e;
endpackage

// File: rtl/i2c_arb_owner.sv
module i2c_arb_owner
  import i2c_engine_arb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   hw_req,
  input  logic   mcu_req,
  input  logic   sw_req,
  input  logic   sw_release,
  input  logic   mcu_only,
  input  logic   eng_done,
  output owner_e owner,
  output logic   preempt
);
  owner_e nxt;

  assign preempt = (owner == OWN_SW) && hw_req;

  always_comb begin
    nxt = owner;
    unique case (owner)
      OWN_IDLE: begin
        if (hw_req)                    nxt = OWN_HW;
        else if (mcu_req)              nxt = OWN_MCU;
        else if (sw_req && !mcu_only)  nxt = OWN_SW;
      end
      OWN_SW: begin
        if (hw_req)          nxt = OWN_HW;
        else if (sw_release) nxt = OWN_IDLE;
      end
      OWN_HW:  if (eng_done) nxt = OWN_IDLE;
      OWN_MCU: if (!mcu_req) nxt = OWN_IDLE;
      default: nxt = OWN_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) owner <= OWN_IDLE;
    else        owner <= nxt;
  end
endmodule

// File: rtl/i2c_arb_swjob.sv
module i2c_arb_swjob #(
  parameter int DESC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              owned,
  input  logic              hw_owned,
  input  logic              go,
  input  logic [DESC_W-1:0] desc,
  input  logic              no_queue,
  input  logic              preempt,
  input  logic              done,
  input  logic              reset_ok,
  input  logic              release_i,
  output logic              launch,
  output logic [DESC_W-1:0] launch_desc,
  output logic              busy
);
  logic              pend;
  logic [DESC_W-1:0] saved;

  // A held job (restart or queued GO) wins over a fresh GO.
  assign launch_desc = pend ? saved : desc;
  assign launch = owned && !busy && (go || pend) && !preempt && !release_i && !reset_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      pend  <= 1'b0;
      saved <= '0;
    end else if (release_i || reset_ok) begin
      busy <= 1'b0;
      pend <= 1'b0;
    end else if (preempt) begin
      if (busy) begin
        pend <= 1'b1;
        busy <= 1'b0;
      end
    end else if (launch) begin
      busy  <= 1'b1;
      pend  <= 1'b0;
      saved <= launch_desc;
    end else if (owned && done) begin
      busy <= 1'b0;
    end else if (hw_owned && go && !no_queue && !pend) begin
      pend  <= 1'b1;
      saved <= desc;
    end
  end
endmodule

// File: rtl/i2c_engine_arb.sv
module i2c_engine_arb
  import i2c_engine_arb_pkg::*;
#(
  parameter int DESC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_use_req,
  input  logic              sw_done_use,
  input  logic              sw_go,
  input  logic [DESC_W-1:0] sw_desc,
  input  logic              sw_status_reset,
  input  logic              no_queue_go,
  input  logic              mcu_only,
  input  logic              mcu_req,
  input  logic              hw_req,
  input  logic [DESC_W-1:0] hw_desc,
  input  logic              eng_done,
  output logic              gnt_sw,
  output logic              gnt_hw,
  output logic              gnt_mcu,
  output logic [1:0]        sw_status,
  output logic              eng_start,
  output logic [DESC_W-1:0] eng_desc,
  output logic              eng_abort
);
  owner_e            owner;
  logic              preempt;
  logic              sw_release;
  logic              reset_ok;
  logic              sw_launch;
  logic              sw_busy;
  logic [DESC_W-1:0] sw_ldesc;
  logic              hw_busy;
  logic              hw_launch;

  assign sw_release = sw_done_use && !sw_use_req;
  assign reset_ok   = sw_status_reset && (owner == OWN_SW);

  i2c_arb_owner u_owner (
    .clk        (clk),
    .rst_n      (rst_n),
    .hw_req     (hw_req),
    .mcu_req    (mcu_req),
    .sw_req     (sw_use_req),
    .sw_release (sw_release),
    .mcu_only   (mcu_only),
    .eng_done   (eng_done),
    .owner      (owner),
    .preempt    (preempt)
  );

  i2c_arb_swjob #(.DESC_W(DESC_W)) u_swjob (
    .clk         (clk),
    .rst_n       (rst_n),
    .owned       (owner == OWN_SW),
    .hw_owned    (owner == OWN_HW),
    .go          (sw_go),
    .desc        (sw_desc),
    .no_queue    (no_queue_go),
    .preempt     (preempt),
    .done        (eng_done),
    .reset_ok    (reset_ok),
    .release_i   (sw_release),
    .launch      (sw_launch),
    .launch_desc (sw_ldesc),
    .busy        (sw_busy)
  );

  assign hw_launch = (owner == OWN_HW) && !hw_busy && !eng_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hw_busy   <= 1'b0;
      eng_start <= 1'b0;
      eng_desc  <= '0;
      eng_abort <= 1'b0;
    end else begin
      if (owner != OWN_HW || eng_done) hw_busy <= 1'b0;
      else if (hw_launch)              hw_busy <= 1'b1;
      eng_start <= hw_launch || sw_launch;
      if (hw_launch)      eng_desc <= hw_desc;
      else if (sw_launch) eng_desc <= sw_ldesc;
      eng_abort <= (preempt || reset_ok) && sw_busy;
    end
  end

  assign gnt_sw    = (owner == OWN_SW);
  assign gnt_hw    = (owner == OWN_HW);
  assign gnt_mcu   = (owner == OWN_MCU);
  assign sw_status = owner;
endmodule

// File: rtl/i2c_engine_arb_chk.sv
module i2c_engine_arb_chk (
  input logic clk,
  input logic rst_n,
  input logic sw_use_req,
  input logic sw_done_use,
  input logic mcu_only,
  input logic hw_req,
  input logic gnt_sw,
  input logic gnt_hw,
  input logic gnt_mcu,
  input logic eng_start
);
  assert_onehot_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gnt_sw, gnt_hw, gnt_mcu}));

  assert_hw_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_sw && !gnt_hw && !gnt_mcu && hw_req) |=> gnt_hw);

  assert_sw_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_sw && !hw_req && !(sw_done_use && !sw_use_req)) |=> gnt_sw);

  assert_lockout_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mcu_only && !gnt_sw) |=> !gnt_sw);

  assert_preempt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_sw && hw_req) |=> gnt_hw);

  assert_start_owner_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> (gnt_sw || gnt_hw));
endmodule

bind i2c_engine_arb i2c_engine_arb_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sw_use_req  (sw_use_req),
  .sw_done_use (sw_done_use),
  .mcu_only    (mcu_only),
  .hw_req      (hw_req),
  .gnt_sw      (gnt_sw),
  .gnt_hw      (gnt_hw),
  .gnt_mcu     (gnt_mcu),
  .eng_start   (eng_start)
);

// File: tb/test_i2c_engine_arb.sv
module test_i2c_engine_arb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sw_use_req = 0, sw_done_use = 0, sw_go = 0, sw_status_reset = 0;
  logic [DW-1:0] sw_desc = '0, hw_desc = '0;
  logic          no_queue_go = 0, mcu_only = 0, mcu_req = 0, hw_req = 0, eng_done = 0;
  logic          gnt_sw, gnt_hw, gnt_mcu, eng_start, eng_abort;
  logic [1:0]    sw_status;
  logic [DW-1:0] eng_desc;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_engine_arb #(.DESC_W(DW)) i_i2c_engine_arb (.*);

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic done_pulse();
    eng_done = 1; tick(); eng_done = 0;
  endtask

  task automatic t_reset();
    rst_n = 0; tick(); tick();
    check("R1 grants", {gnt_sw, gnt_hw, gnt_mcu}, 0);
    rst_n = 1; tick();
    check("R1 status", sw_status, 0);
    check("R1 start/abort", {eng_start, eng_abort}, 0);
  endtask

  task automatic t_sw_basic();
    sw_use_req = 1; tick();
    check("R3 sw grant", gnt_sw, 1);
    check("R4 status sw", sw_status, 1);
    sw_go = 1; sw_desc = 12'hA51; tick(); sw_go = 0;
    check("R10 sw start", eng_start, 1);
    check("R10 sw desc", eng_desc, 12'hA51);
    tick();
    check("R10 single pulse", eng_start, 0);
    done_pulse();
    repeat (3) tick();
    check("R3 grant held", gnt_sw, 1);
  endtask

  task automatic t_preempt();
    sw_go = 1; sw_desc = 12'h93C; tick(); sw_go = 0;
    check("R10 start", eng_start, 1);
    hw_req = 1; hw_desc = 12'h777; tick();
    check("R6 hw grant", gnt_hw, 1);
    check("R6 abort", eng_abort, 1);
    check("R4 status hw", sw_status, 2);
    tick();
    check("R10 hw start", eng_start, 1);
    check("R10 hw desc", eng_desc, 12'h777);
    hw_req = 0;
    done_pulse();
    check("R7 idle after hw", sw_status, 0);
    tick();
    check("R7 sw regrant", gnt_sw, 1);
    tick();
    check("R7 restart", eng_start, 1);
    check("R7 restart desc", eng_desc, 12'h93C);
    done_pulse();
  endtask

  task automatic t_queue(logic opt, logic [DW-1:0] d);
    no_queue_go = opt;
    hw_req = 1; hw_desc = 12'h5E0; tick();
    check("R8 hw owns", gnt_hw, 1);
    tick(); hw_req = 0;
    sw_go = 1; sw_desc = d; tick(); sw_go = 0;
    sw_status_reset = 1; tick(); sw_status_reset = 0;
    check("R9 reset ignored no abort", eng_abort, 0);
    check("R9 status still hw", sw_status, 2);
    done_pulse(); tick();
    check("R8 sw back", gnt_sw, 1);
    tick();
    check("R8 queued start", eng_start, opt ? 0 : 1);
    if (!opt) begin
      check("R8 queued desc", eng_desc, d);
      done_pulse();
    end else begin
      tick(); tick();
      check("R8 dropped stays quiet", eng_start, 0);
    end
    no_queue_go = 0;
  endtask

  task automatic t_sw_reset();
    sw_go = 1; sw_desc = 12'h844; tick(); sw_go = 0;
    check("R10 start", eng_start, 1);
    sw_status_reset = 1; tick(); sw_status_reset = 0;
    check("R9 reset abort", eng_abort, 1);
    sw_go = 1; sw_desc = 12'hF55; tick(); sw_go = 0;
    check("R9 engine free after reset", eng_start, 1);
    check("R9 new desc", eng_desc, 12'hF55);
    done_pulse();
  endtask

  task automatic t_lockout();
    sw_done_use = 1; sw_use_req = 0; tick(); sw_done_use = 0;
    check("R3 released", sw_status, 0);
    mcu_only = 1; sw_use_req = 1;
    for (int i = 0; i < 5; i++) begin
      tick();
      check("R5 locked out", gnt_sw, 0);
    end
    mcu_only = 0; tick();
    check("R5 granted after lockout", gnt_sw, 1);
    sw_done_use = 1; sw_use_req = 0; tick(); sw_done_use = 0;
    check("R3 released again", sw_status, 0);
  endtask

  task automatic t_priority();
    hw_req = 1; mcu_req = 1; sw_use_req = 1; hw_desc = 12'hB0B; tick();
    check("R2 hw first", gnt_hw, 1);
    check("R2 one-hot", {gnt_sw, gnt_mcu}, 0);
    tick();
    check("R10 hw start", eng_start, 1);
    hw_req = 0;
    done_pulse(); tick();
    check("R2 mcu second", gnt_mcu, 1);
    check("R4 status mcu", sw_status, 3);
    mcu_req = 0; tick(); tick();
    check("R2 sw last", gnt_sw, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0;
    tick();
    t_reset();
    t_sw_basic();
    t_preempt();
    t_queue(1'b0, 12'hC11);
    t_queue(1'b1, 12'hD22);
    t_sw_reset();
    t_lockout();
    t_priority();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule